// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the multiply-accumulate execution unit of a 32-bit integer pipeline. The issue stage hands it an instruction word and the values of its two source registers. The unit owns the HI/LO accumulator pair. It adds a product to that pair and returns one half of the new value for the destination register.

Three control bits in the instruction word pick the flavour of the operation. The first bit chooses between two kinds of accumulation. In one, 16-bit operands feed a 32-bit accumulation that clamps at the edges of its range. In the other, full 32-bit operands feed a 64-bit accumulation that wraps. The second bit chooses signed or unsigned arithmetic. The third chooses whether the destination register receives the new HI or the new LO.

Only one operation is in flight at a time. The issue port stays not-ready until the result has been written back, so each operation always sees the accumulator left by the previous one. No arithmetic overflow is ever signalled.

Top module: `mac_sat_unit`

## Requirements
- R1: An instruction word is taken as a multiply-accumulate only when all of these hold: bits 31:26 are 6'b000000, bits 5:0 are 6'b101000, and bits 7:6 are zero. Bit 10 is the saturate bit (1 = saturating), bit 9 is the HI-select bit (1 = destination gets HI), and bit 8 is the unsigned bit (1 = unsigned). The destination register number in bits 15:11 is returned on `wb_rd`.
- R2: A word accepted on the issue port that does not match R1 is consumed without effect. `wb_valid` stays low, HI and LO keep their values, and `issue_ready` stays high.
- R3: A matching word accepted at clock edge E0 writes HI, LO and the destination in the same cycle, at edge E0+LATENCY (default 3). `wb_valid` is high for exactly that one cycle.
- R4: `issue_ready` falls at the edge that accepts a matching word and rises again at the write-back edge.
- R5: Wrapping signed mode (saturate bit 0, unsigned bit 0): the signed 64-bit product of the full operands is added to {HI, LO} modulo 2^64.
- R6: Wrapping unsigned mode (saturate bit 0, unsigned bit 1): as in R5, but both operands are taken as unsigned 32-bit values.
- R7: Saturating signed mode (saturate bit 1, unsigned bit 0) works as follows. Only bits 15:0 of each operand are used, as two's-complement values. Their product is added to LO, taken as signed. The sum is clamped to the range 32'h8000_0000 to 32'h7FFF_FFFF and written to LO, and HI receives the sign extension of LO.
- R8: Saturating unsigned mode (saturate bit 1, unsigned bit 1) works as follows. Only bits 15:0 of each operand are used, as unsigned values. Their product is added to LO, taken as unsigned. The sum is clamped to 32'hFFFF_FFFF, written to LO, and HI becomes zero.
- R9: `wb_data` equals the new HI when the HI-select bit is 1 and the new LO when it is 0.
- R10: Reset clears HI and LO to zero, holds `wb_valid` low and leaves `issue_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | Issue stage presents an instruction |
| issue_ready | output | 1 | Unit can accept an instruction |
| issue_instr | input | 32 | Instruction word |
| src_a | input | XLEN | First source register value |
| src_b | input | XLEN | Second source register value |
| wb_valid | output | 1 | Write-back strobe for destination and HI/LO |
| wb_rd | output | 5 | Destination register number |
| wb_data | output | XLEN | Value for the destination register |
| hi_out | output | XLEN | Current HI accumulator |
| lo_out | output | XLEN | Current LO accumulator |

## Verification
Several properties are checked on every cycle:
- HI and LO change only in the write-back cycle.
- A write-back comes exactly LATENCY edges after a matching issue and lasts one cycle.
- The ready flag drops and returns around each operation.
- The destination value is a copy of one accumulator half.
- In saturating mode, HI is the proper extension of LO.

The arithmetic itself is shown only by the bench scenarios. They compare against an independent model: signed and unsigned 64-bit wrap-around, clamping at each saturation limit, operands with junk in their upper bits, decode rejection of near-miss words, and a reset in mid-run.

// File: rtl/mac_pkg.sv
package mac_pkg;
   localparam logic [5:0] MAJOR_SPECIAL = 6'b000000;
   localparam logic [5:0] FUNC_MACC     = 6'b101000;

   typedef struct packed {
      logic sat;
      logic hi;
      logic us;
   } mac_mode_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
   import mac_pkg::*;
(
   input  logic [31:0] instr,
   output logic        hit,
   output mac_mode_t   mode,
   output logic [4:0]  rd
);
   logic unused_fields;

   assign hit  = (instr[31:26] == MAJOR_SPECIAL) &&
                 (instr[5:0]   == FUNC_MACC) &&
                 (instr[7:6]   == 2'b00);
   assign mode = '{sat: instr[10], hi: instr[9], us: instr[8]};
   assign rd   = instr[15:11];
   assign unused_fields = ^instr[25:16];
endmodule

// File: rtl/mac_mult.sv
module mac_mult
   import mac_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [XLEN-1:0]   op_a,
   input  logic [XLEN-1:0]   op_b,
   input  mac_mode_t         in_mode,
   input  logic [4:0]        in_rd,
   output logic              out_vld,
   output logic [2*XLEN-1:0] out_prod,
   output mac_mode_t         out_mode,
   output logic [4:0]        out_rd
);
   localparam int HALF = XLEN / 2;
   localparam int PW   = 2 * XLEN;

   logic signed [XLEN:0]     ext_a, ext_b;
   logic signed [PW+1:0]     prod_full;
   logic                     unused_top;

   function automatic logic signed [XLEN:0] shape(input logic [XLEN-1:0] v,
                                                  input mac_mode_t m);
      logic signed [XLEN:0] r;
      if (m.sat) begin
         if (m.us) r = {{(HALF+1){1'b0}}, v[HALF-1:0]};
         else      r = {{(HALF+1){v[HALF-1]}}, v[HALF-1:0]};
      end else begin
         if (m.us) r = {1'b0, v};
         else      r = {v[XLEN-1], v};
      end
      return r;
   endfunction

   always_comb begin
      ext_a     = shape(op_a, in_mode);
      ext_b     = shape(op_b, in_mode);
      prod_full = ext_a * ext_b;
   end
   assign unused_top = ^prod_full[PW+1:PW];

   logic              vld_q  [STAGES];
   logic [PW-1:0]     prod_q [STAGES];
   mac_mode_t         mode_q [STAGES];
   logic [4:0]        rd_q   [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) vld_q[k] <= 1'b0;
      end else begin
         vld_q[0] <= in_vld;
         for (int k = 1; k < STAGES; k++) vld_q[k] <= vld_q[k-1];
      end
   end

   always_ff @(posedge clk) begin
      prod_q[0] <= prod_full[PW-1:0];
      mode_q[0] <= in_mode;
      rd_q[0]   <= in_rd;
      for (int k = 1; k < STAGES; k++) begin
         prod_q[k] <= prod_q[k-1];
         mode_q[k] <= mode_q[k-1];
         rd_q[k]   <= rd_q[k-1];
      end
   end

   generate
      if (STAGES == 1) begin : g_single
         assign out_vld  = vld_q[0];
         assign out_prod = prod_q[0];
         assign out_mode = mode_q[0];
         assign out_rd   = rd_q[0];
      end else begin : g_chain
         assign out_vld  = vld_q[STAGES-1];
         assign out_prod = prod_q[STAGES-1];
         assign out_mode = mode_q[STAGES-1];
         assign out_rd   = rd_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mac_accum.sv
module mac_accum
   import mac_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]   hi_cur,
   input  logic [XLEN-1:0]   lo_cur,
   input  logic [2*XLEN-1:0] prod,
   input  mac_mode_t         mode,
   output logic [XLEN-1:0]   hi_nxt,
   output logic [XLEN-1:0]   lo_nxt
);
   localparam int SW = XLEN + 3;
   localparam logic signed [SW-1:0] S_MAX = {{4{1'b0}}, {(XLEN-1){1'b1}}};
   localparam logic signed [SW-1:0] S_MIN = {{4{1'b1}}, {(XLEN-1){1'b0}}};
   localparam logic signed [SW-1:0] U_MAX = {3'b000, {XLEN{1'b1}}};

   logic [2*XLEN-1:0]     wrap_sum;
   logic signed [SW-1:0]  acc_x, prd_x, sat_sum;
   logic [XLEN-1:0]       clamped;
   logic                  unused_prod;

   assign unused_prod = ^prod[2*XLEN-1:XLEN+2];

   always_comb begin
      wrap_sum = {hi_cur, lo_cur} + prod;
      acc_x    = mode.us ? {3'b000, lo_cur} : {{3{lo_cur[XLEN-1]}}, lo_cur};
      prd_x    = {prod[XLEN+1], prod[XLEN+1:0]};
      sat_sum  = acc_x + prd_x;
      if (mode.us) begin
         if (sat_sum > U_MAX)          clamped = {XLEN{1'b1}};
         else if (sat_sum < 0)         clamped = '0;
         else                          clamped = sat_sum[XLEN-1:0];
      end else begin
         if (sat_sum > S_MAX)          clamped = S_MAX[XLEN-1:0];
         else if (sat_sum < S_MIN)     clamped = S_MIN[XLEN-1:0];
         else                          clamped = sat_sum[XLEN-1:0];
      end
      if (mode.sat) begin
         lo_nxt = clamped;
         hi_nxt = mode.us ? '0 : {XLEN{clamped[XLEN-1]}};
      end else begin
         lo_nxt = wrap_sum[XLEN-1:0];
         hi_nxt = wrap_sum[2*XLEN-1:XLEN];
      end
   end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
   import mac_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int LATENCY = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_valid,
   output logic            issue_ready,
   input  logic [31:0]     issue_instr,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic            wb_valid,
   output logic [4:0]      wb_rd,
   output logic [XLEN-1:0] wb_data,
   output logic [XLEN-1:0] hi_out,
   output logic [XLEN-1:0] lo_out
);
   localparam int MUL_STAGES = LATENCY - 1;

   generate
      if (LATENCY < 2) begin : g_bad_latency
         $error("mac_sat_unit: LATENCY must be at least 2");
      end
      if ((XLEN % 2) != 0 || XLEN < 8) begin : g_bad_xlen
         $error("mac_sat_unit: XLEN must be even and at least 8");
      end
   endgenerate

   logic            dec_hit;
   mac_mode_t       dec_mode;
   logic [4:0]      dec_rd;
   logic            accept;
   logic            busy;

   logic            s0_vld;
   logic [XLEN-1:0] s0_a, s0_b;
   mac_mode_t       s0_mode;
   logic [4:0]      s0_rd;

   logic              m_vld;
   logic [2*XLEN-1:0] m_prod;
   mac_mode_t         m_mode;
   logic [4:0]        m_rd;

   logic [XLEN-1:0] hi_q, lo_q, hi_n, lo_n;
   logic            wb_sat_q, wb_us_q;

   mac_decode u_dec (
      .instr (issue_instr),
      .hit   (dec_hit),
      .mode  (dec_mode),
      .rd    (dec_rd)
   );

   assign issue_ready = !busy;
   assign accept      = issue_valid && issue_ready && dec_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         s0_vld <= 1'b0;
      end else begin
         s0_vld <= accept;
         if (accept)     busy <= 1'b1;
         else if (m_vld) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         s0_a    <= src_a;
         s0_b    <= src_b;
         s0_mode <= dec_mode;
         s0_rd   <= dec_rd;
      end
   end

   mac_mult #(.XLEN(XLEN), .STAGES(MUL_STAGES)) u_mult (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (s0_vld),
      .op_a     (s0_a),
      .op_b     (s0_b),
      .in_mode  (s0_mode),
      .in_rd    (s0_rd),
      .out_vld  (m_vld),
      .out_prod (m_prod),
      .out_mode (m_mode),
      .out_rd   (m_rd)
   );

   mac_accum #(.XLEN(XLEN)) u_acc (
      .hi_cur (hi_q),
      .lo_cur (lo_q),
      .prod   (m_prod),
      .mode   (m_mode),
      .hi_nxt (hi_n),
      .lo_nxt (lo_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q     <= '0;
         lo_q     <= '0;
         wb_valid <= 1'b0;
         wb_rd    <= '0;
         wb_data  <= '0;
         wb_sat_q <= 1'b0;
         wb_us_q  <= 1'b0;
      end else begin
         wb_valid <= m_vld;
         if (m_vld) begin
            hi_q     <= hi_n;
            lo_q     <= lo_n;
            wb_rd    <= m_rd;
            wb_data  <= m_mode.hi ? hi_n : lo_n;
            wb_sat_q <= m_mode.sat;
            wb_us_q  <= m_mode.us;
         end
      end
   end

   assign hi_out = hi_q;
   assign lo_out = lo_q;
endmodule

// File: rtl/mac_sat_chk.sv
module mac_sat_chk #(
   parameter int XLEN    = 32,
   parameter int LATENCY = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue_valid,
   input logic            issue_ready,
   input logic            dec_hit,
   input logic            wb_valid,
   input logic [XLEN-1:0] wb_data,
   input logic [XLEN-1:0] hi_out,
   input logic [XLEN-1:0] lo_out,
   input logic            wb_sat,
   input logic            wb_us
);
   localparam int AW = $clog2(LATENCY + 1) + 1;

   logic          pend;
   logic [AW-1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         age  <= '0;
      end else if (issue_valid && issue_ready && dec_hit) begin
         pend <= 1'b1;
         age  <= '0;
      end else if (wb_valid) begin
         pend <= 1'b0;
      end else if (pend) begin
         age <= age + 1'b1;
      end
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && dec_hit) |=> !issue_ready); // R4
   AST_READY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> issue_ready); // R4
   AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid); // R3
   AST_WB_AGE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (pend && age == AW'(LATENCY))); // R3
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_valid |-> ($stable(hi_out) && $stable(lo_out))); // R2
   AST_DEST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_data == hi_out || wb_data == lo_out)); // R9
   AST_SAT_HI_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_sat && !wb_us) |-> (hi_out == {XLEN{lo_out[XLEN-1]}})); // R7
   AST_SAT_HI_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_sat && wb_us) |-> (hi_out == '0)); // R8
endmodule

bind mac_sat_unit mac_sat_chk #(.XLEN(XLEN), .LATENCY(LATENCY)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_ready (issue_ready),
   .dec_hit     (dec_hit),
   .wb_valid    (wb_valid),
   .wb_data     (wb_data),
   .hi_out      (hi_out),
   .lo_out      (lo_out),
   .wb_sat      (wb_sat_q),
   .wb_us       (wb_us_q)
);

// File: tb/tb_mac_sat_unit.sv
`timescale 1ns/1ps
module tb_mac_sat_unit;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic        issue_ready;
   logic [31:0] issue_instr = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic        wb_valid;
   logic [4:0]  wb_rd;
   logic [31:0] wb_data, hi_out, lo_out;

   mac_sat_unit #(.XLEN(32), .LATENCY(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_instr(issue_instr), .src_a(src_a), .src_b(src_b), .wb_valid(wb_valid),
      .wb_rd(wb_rd), .wb_data(wb_data), .hi_out(hi_out), .lo_out(lo_out)
   );

   always #2 clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [4:0]  rd;
      logic [31:0] data, hi, lo;
      int unsigned cyc;
      string       req;
   } exp_t;
   exp_t sb[$];

   int n_cmp = 0, n_bad = 0;
   logic [31:0] m_hi = '0, m_lo = '0;
   bit done = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [4:0] rd, input logic [2:0] m);
      return {6'b000000, 5'd3, 5'd4, rd, m, 2'b00, 6'b101000};
   endfunction

   task automatic model(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] p;
      longint pa, pb, acc, s;
      if (!m[2]) begin
         if (m[0]) p = {32'b0, a} * {32'b0, b};
         else      p = 64'(longint'($signed(a)) * longint'($signed(b)));
         {m_hi, m_lo} = {m_hi, m_lo} + p;
      end else begin
         pa  = m[0] ? longint'(a[15:0]) : longint'($signed(a[15:0]));
         pb  = m[0] ? longint'(b[15:0]) : longint'($signed(b[15:0]));
         acc = m[0] ? longint'(m_lo)    : longint'($signed(m_lo));
         s   = acc + pa * pb;
         if (m[0]) begin
            if (s > 64'sd4294967295) m_lo = 32'hFFFF_FFFF;
            else if (s < 0)          m_lo = 32'h0;
            else                     m_lo = s[31:0];
            m_hi = 32'h0;
         end else begin
            if (s > 64'sd2147483647)       m_lo = 32'h7FFF_FFFF;
            else if (s < -64'sd2147483648) m_lo = 32'h8000_0000;
            else                           m_lo = s[31:0];
            m_hi = {32{m_lo[31]}};
         end
      end
   endtask

   // Driver: presents one word, predicts the result and pushes it to the scoreboard.
   task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input bit hit, input string req);
      exp_t e;
      @(negedge clk);
      issue_valid = 1'b1; issue_instr = w; src_a = a; src_b = b;
      while (!issue_ready) @(negedge clk);
      if (hit) begin
         model({w[10], w[9], w[8]}, a, b);
         e.rd = w[15:11]; e.hi = m_hi; e.lo = m_lo;
         e.data = w[9] ? m_hi : m_lo;
         e.cyc = cyc + 1 + LAT; e.req = req;
         sb.push_back(e);
      end
      @(posedge clk);
      @(negedge clk);
      issue_valid = 1'b0;
      chk(hit ? "R4 ready low after accept" : "R2 ready stays high", issue_ready, !hit);
      if (hit) begin
         while (sb.size() != 0) @(negedge clk);
      end else begin
         repeat (LAT + 2) @(negedge clk);
         chk("R2 HI unchanged", hi_out, m_hi);
         chk("R2 LO unchanged", lo_out, m_lo);
      end
   endtask

   // Monitor: pops expected items as write-backs appear.
   always @(negedge clk) begin
      if (rst_n && wb_valid) begin
         if (sb.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 unexpected write-back: actual rd %0d data %h expected none", wb_rd, wb_data);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.req, " HI"}, hi_out, e.hi);
            chk({e.req, " LO"}, lo_out, e.lo);
            chk("R9 destination data", wb_data, e.data);
            chk("R1 destination number", wb_rd, e.rd);
            chk("R3 write-back cycle", cyc, e.cyc);
            chk("R4 ready back at write-back", issue_ready, 1);
         end
      end
   end

   task automatic check_reset_state();
      chk("R10 HI cleared", hi_out, 0);
      chk("R10 LO cleared", lo_out, 0);
      chk("R10 no write-back", wb_valid, 0);
      chk("R10 ready high", issue_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();

      // wrapping signed / unsigned
      issue(mk(5'd5, 3'b000), 32'hFFFF_FFFD, 32'd7, 1, "R5 signed wrap");
      issue(mk(5'd6, 3'b001), 32'hFFFF_FFFF, 32'd2, 1, "R6 unsigned wrap");
      issue(mk(5'd7, 3'b010), 32'h8000_0000, 32'h8000_0000, 1, "R5 signed wrap HI dest");
      issue(mk(5'd8, 3'b011), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R6 unsigned wrap HI dest");
      issue(mk(5'd9, 3'b011), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R6 unsigned wrap past 2^64");

      // near-miss words
      issue(mk(5'd4, 3'b000) ^ 32'h0000_0001, 32'd5, 32'd5, 0, "R1 bad function");
      issue(mk(5'd4, 3'b000) | 32'h0000_0080, 32'd5, 32'd5, 0, "R1 bit 7 set");
      issue(mk(5'd4, 3'b000) | 32'h0400_0000, 32'd5, 32'd5, 0, "R1 bad major opcode");

      // saturating signed, clamp high, with junk in the upper operand bits
      for (int i = 0; i < 6; i++)
         issue(mk(5'd10, 3'b100), 32'h1234_7FFF, 32'hABCD_7FFF, 1, "R7 signed clamp high");
      // saturating signed, clamp low, HI destination
      for (int i = 0; i < 10; i++)
         issue(mk(5'd11, 3'b110), 32'h0000_8000, 32'h5555_7FFF, 1, "R7 signed clamp low");
      issue(mk(5'd12, 3'b110), 32'h0000_0003, 32'h0000_0004, 1, "R7 signed near limit");
      // saturating unsigned
      for (int i = 0; i < 4; i++)
         issue(mk(5'd13, 3'b101), 32'hABCD_FFFF, 32'h0001_FFFF, 1, "R8 unsigned clamp");
      issue(mk(5'd14, 3'b111), 32'h0000_0002, 32'h0000_0003, 1, "R8 unsigned HI dest");

      // mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_hi = '0; m_lo = '0;
      @(negedge clk);
      check_reset_state();
      issue(mk(5'd31, 3'b000), 32'd100, 32'hFFFF_FF9C, 1, "R5 after reset");
      issue(mk(5'd1, 3'b100), 32'hFFFF_0010, 32'h0000_0010, 1, "R7 small add");

      repeat (4) @(negedge clk);
      chk("R2 scoreboard drained", sb.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule